// File: doc/BRIEF.md
# Watchdog Timer with Selectable Clock Source and Tap

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources chosen by a static configuration input. One source is a free-running low-speed oscillator, which reaches the block as a single-cycle enable. The other is the system clock divided by four inside the block. Ticks feed a prescaler stage and then a counter. A select field picks one of the tap points in that chain, and this sets the time-out period to a power of two ticks.

Software restarts the count with a clear command. When the core halts with the oscillator source selected, the count restarts and keeps running through power-down. When the core halts with the divided system clock selected, the count freezes, because that clock stops in power-down.

A time-out is a single-cycle pulse. A flag goes with the pulse and tells the reset controller whether the core was halted at that moment. The controller can then choose a warm restart instead of a full device reset.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the prescaler, the counter and the divider are zero, and tmo_pulse and tmo_warm are low. With the oscillator source and a tick on every cycle, the first time-out pulse is seen 2^PRE_W clock edges after reset is released.
- R2: When src_osc=1, only cycles with osc_tick=1 count as ticks. When src_osc=0, osc_tick is ignored and one tick occurs on every fourth clock edge after a clear, so N ticks take 4N edges.
- R3: The time-out fires on the tick that completes 2^(PRE_W+tap_sel) ticks since the last clear, for every tap_sel value from 0 to 7. It then repeats with the same period while no clear arrives.
- R4: tmo_pulse is registered. It goes high in the cycle after the completing tick and stays high for exactly one cycle.
- R5: sw_clear zeroes the prescaler, the counter and the divider on the next edge. It wins over a tick in the same cycle, and no pulse follows that edge.
- R6: On the first edge at which halted is seen high (halt entry) with src_osc=1, the chain is cleared. Counting then continues, so the pulse comes 2^(PRE_W+tap_sel) ticks after that edge.
- R7: While src_osc=0 and halted=1, the divider, prescaler and counter hold their values and no pulse occurs. Counting resumes from the held state when halted falls.
- R8: tmo_warm is high together with tmo_pulse exactly when halted was 1 on the completing tick, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_osc | input | 1 | Static source select: 1 = oscillator enable, 0 = system clock divided by four |
| osc_tick | input | 1 | Single-cycle enable from the low-speed oscillator |
| halted | input | 1 | Level, high while the core is in power-down |
| sw_clear | input | 1 | Software clear command |
| tap_sel | input | SEL_W (3) | Tap select; the period is 2^(PRE_W+tap_sel) ticks |
| tmo_pulse | output | 1 | One-cycle time-out pulse |
| tmo_warm | output | 1 | High with tmo_pulse when the core was halted at time-out |

## Verification
Every result is due a fixed number of edges after the clear edge. With the oscillator source it is 2^(PRE_W+tap_sel) edges. With the divided source it is four times that. After a halt entry it is one clear edge plus the period. In the freeze case the held edges add to the total. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the edge that applies a clear or halt until the pulse is first seen, and compares that count with the figure it computes for itself. It also checks that the pulse is low one edge later and that no pulse appears after a clear edge or while the count is frozen.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {SRC_SYSDIV = 1'b0, SRC_OSC = 1'b1} wd_src_e;

  // ticks from clear to time-out for a given prescaler width and tap
  function automatic int unsigned tmo_ticks(input int unsigned pre_w,
                                            input int unsigned sel);
    return 32'd1 << (pre_w + sel);
  endfunction
endpackage

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_osc,
  input  logic osc_tick,
  input  logic halted,
  input  logic clr,
  output logic tick,
  output logic frz
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          div_end;

  assign frz     = (src_osc == wdog_pkg::SRC_SYSDIV) && halted;
  assign div_end = (div_q == LAST);
  assign tick    = src_osc ? osc_tick : (div_end && !frz);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) div_q <= '0;
    else if (!src_osc && !frz) div_q <= div_end ? '0 : div_q + 1'b1;
  end

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_osc && tick) |=> !tick);                                   // R2
  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !clr) |=> $stable(div_q));                               // R7
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   clr,
  input  logic                   frz,
  output logic [PRE_W+CNT_W-1:0] count
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] ctr_q;
  logic             pre_wrap;

  assign pre_wrap = &pre_q;
  assign count    = {ctr_q, pre_q};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre_q <= '0;
      ctr_q <= '0;
    end else if (tick) begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap) ctr_q <= ctr_q + 1'b1;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));                                          // R5
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !clr) |=> $stable(count));                               // R7
endmodule

// File: rtl/wdog_tap.sv
module wdog_tap #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 7,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PRE_W+CNT_W-1:0] count,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   tick,
  input  logic                   clr,
  input  logic                   halted,
  output logic                   pulse,
  output logic                   warm
);
  localparam int NTAP  = CNT_W + 1;
  localparam int NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0] tap_full;
  logic             fire;

  // tap k is full when the low PRE_W+k bits are all ones
  for (genvar k = 0; k < NSLOT; k++) begin : g_tap
    if (k < NTAP) begin : g_used
      assign tap_full[k] = &count[PRE_W+k-1:0];
    end else begin : g_spare
      assign tap_full[k] = 1'b0;
    end
  end

  assign fire = tick && tap_full[sel] && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      warm  <= 1'b0;
    end else begin
      pulse <= fire;
      warm  <= fire && halted;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);                                               // R4
  AST_WARM_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> pulse);                                                 // R8
  AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);                                                 // R5
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter  int PRE_W = 8,
  parameter  int CNT_W = 7,
  localparam int SEL_W = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_osc,
  input  logic             osc_tick,
  input  logic             halted,
  input  logic             sw_clear,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tmo_pulse,
  output logic             tmo_warm
);
  localparam int CW = PRE_W + CNT_W;

  logic          halt_q;
  logic          halt_rise;
  logic          clr;
  logic          tick;
  logic          frz;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halted;
  end

  assign halt_rise = halted && !halt_q;
  assign clr       = sw_clear || (halt_rise && src_osc);

  wdog_tickgen #(.DIV(4)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_osc(src_osc), .osc_tick(osc_tick),
    .halted(halted), .clr(clr), .tick(tick), .frz(frz)
  );

  wdog_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .frz(frz),
    .count(count)
  );

  wdog_tap #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .count(count), .sel(tap_sel), .tick(tick),
    .clr(clr), .halted(halted), .pulse(tmo_pulse), .warm(tmo_warm)
  );

  AST_HALT_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_rise && src_osc) |=> (count == '0));                       // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!tmo_pulse && !tmo_warm));                           // R1
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int BPRE = 3;
  localparam int BCNT = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_osc = 1'b1;
  logic       osc_tick = 1'b1;
  logic       halted = 1'b0;
  logic       sw_clear = 1'b0;
  logic [2:0] tap_sel = 3'd0;
  logic       tmo_pulse, tmo_warm;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdog_timer #(.PRE_W(BPRE), .CNT_W(BCNT)) u0 (
    .clk(clk), .rst_n(rst_n), .src_osc(src_osc), .osc_tick(osc_tick),
    .halted(halted), .sw_clear(sw_clear), .tap_sel(tap_sel),
    .tmo_pulse(tmo_pulse), .tmo_warm(tmo_warm)
  );

  // ticks to time-out, built by repeated doubling
  function automatic int ticks_for(input int sel);
    int v = 1;
    for (int i = 0; i < BPRE + sel; i++) v = v * 2;
    return v;
  endfunction

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_clear();
    sw_clear = 1'b1;
    step(1);
    sw_clear = 1'b0;
  endtask

  task automatic wait_pulse(output int n, output bit w, input int limit);
    n = 0; w = 0;
    while (n < limit) begin
      step(1);
      n++;
      if (tmo_pulse) begin w = tmo_warm; break; end
    end
  endtask

  task automatic t_reset();
    int n; bit w;
    chk(tmo_pulse == 0, "R1", "pulse in reset", tmo_pulse, 0);
    chk(tmo_warm == 0, "R1", "warm in reset", tmo_warm, 0);
    rst_n = 1'b1;
    wait_pulse(n, w, 100);
    chk(n == ticks_for(0), "R1", "edges to first pulse", n, ticks_for(0));
  endtask

  task automatic t_period_osc();
    int n; bit w;
    src_osc = 1'b1; osc_tick = 1'b1;
    for (int s = 0; s < 8; s++) begin
      tap_sel = 3'(s);
      do_clear();
      wait_pulse(n, w, ticks_for(s) + 20);
      chk(n == ticks_for(s), "R3", $sformatf("osc sel %0d period", s), n, ticks_for(s));
      chk(w == 0, "R8", "warm while running", w, 0);
    end
    wait_pulse(n, w, ticks_for(7) + 20);
    chk(n == ticks_for(7), "R3", "repeat period sel 7", n, ticks_for(7));
    step(1);
    chk(tmo_pulse == 0, "R4", "pulse width one cycle", tmo_pulse, 0);
  endtask

  task automatic t_period_div();
    int n; bit w;
    src_osc = 1'b0; osc_tick = 1'b0;
    for (int s = 0; s < 8; s++) begin
      tap_sel = 3'(s);
      do_clear();
      wait_pulse(n, w, 4 * ticks_for(s) + 20);
      chk(n == 4 * ticks_for(s), "R2", $sformatf("sysclk/4 sel %0d period", s), n, 4 * ticks_for(s));
    end
    osc_tick = 1'b1;
  endtask

  task automatic t_no_osc_tick();
    int n; bit w;
    src_osc = 1'b1; tap_sel = 3'd0; osc_tick = 1'b0;
    do_clear();
    wait_pulse(n, w, 50);
    chk(n == 50, "R2", "no pulse without osc ticks", n, 50);
    osc_tick = 1'b1;
    wait_pulse(n, w, 30);
    chk(n == ticks_for(0), "R2", "count only on osc ticks", n, ticks_for(0));
  endtask

  task automatic t_clear_priority();
    int n; bit w;
    src_osc = 1'b1; osc_tick = 1'b1; tap_sel = 3'd0;
    do_clear();
    step(ticks_for(0) - 1);
    sw_clear = 1'b1;
    step(1);
    sw_clear = 1'b0;
    chk(tmo_pulse == 0, "R5", "clear beats completing tick", tmo_pulse, 0);
    wait_pulse(n, w, 30);
    chk(n == ticks_for(0), "R5", "count restarts after clear", n, ticks_for(0));
  endtask

  task automatic t_halt_osc();
    int n; bit w;
    src_osc = 1'b1; osc_tick = 1'b1; tap_sel = 3'd0;
    do_clear();
    step(5);
    halted = 1'b1;
    wait_pulse(n, w, 40);
    chk(n == ticks_for(0) + 1, "R6", "halt entry restarts count", n, ticks_for(0) + 1);
    chk(w == 1, "R8", "warm flag when halted", w, 1);
    halted = 1'b0;
    step(2);
  endtask

  task automatic t_freeze();
    int n; bit w; int seen;
    src_osc = 1'b0; tap_sel = 3'd0;
    do_clear();
    step(12);
    halted = 1'b1;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (tmo_pulse) seen++;
    end
    chk(seen == 0, "R7", "no pulse while frozen", seen, 0);
    halted = 1'b0;
    wait_pulse(n, w, 60);
    chk(n == 4 * ticks_for(0) - 12, "R7", "count resumes from held state", n, 4 * ticks_for(0) - 12);
    chk(w == 0, "R8", "no warm after leaving halt", w, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_period_osc();
    t_period_div();
    t_no_osc_tick();
    t_clear_priority();
    t_halt_osc();
    t_freeze();
    finish_up();
  end
endmodule